// File: doc/BRIEF.md
# Three-Channel Timer Bus Interface with Read-Back Latches

This block is the host-side front end of a three-channel interval timer. It turns the chip-select, read-strobe, write-strobe and two address lines into one of a small set of bus actions. Those actions are a byte write to one of the three counters, a control-word write, a byte read from one of the counters, or an idle bus with the data output disabled. The counting engines sit outside the block. Each one supplies a live 16-bit count and a live 8-bit status byte.

A read-back command is a control-word write with its two top bits set. It can freeze the count, the status byte, or both, for any subset of the three counters in a single write. Each counter has one count latch and one status latch, and they work independently. A request for a latch that is already holding a value is dropped for that latch alone. Later reads of a counter drain its latches in a fixed order: status first, then the count low byte, then the high byte. Each latch empties as soon as its bytes have been read. A counter with no full latch returns its live count, low byte first.

Every clock cycle in which a read or write is active counts as one bus access. Write strobes and read data are combinational in that cycle. Latch state changes at the closing clock edge.

Top module: `rb_latch_ctrl`

## Requirements
- R1: With cs_n=0, wr_n=0, rd_n=1 and addr 0, 1 or 2, `wr_cnt` is one-hot with bit `addr` set. In the same cycle `wr_data` equals `din` and `wr_ctl` is 0.
- R2: A write to addr 3 pulses `wr_ctl` when din[7:6] is not 2'b11. When din[7:6] is 2'b11 the write is a read-back command and `wr_ctl` stays 0.
- R3: `dout_oe` is 1 and no write strobe fires only when cs_n=0, rd_n=0, wr_n=1 and addr is 0 to 2. The bus is idle (`dout_oe`=0, `dout`=0, no strobes) when cs_n=1, when rd_n and wr_n are both 1, when both are 0, or on a read of addr 3.
- R4: With no latch full, successive reads of a counter return its live count, low byte and then high byte, alternating.
- R5: Read-back bit din[5]=0 latches the live count of every counter selected by din[1], din[2] and din[3] (counters 0, 1, 2). The latched value stays frozen while the live count moves, and it is read low byte then high byte.
- R6: Read-back bit din[4]=0 latches the live status byte of each selected counter. The next read of that counter returns the latched status byte.
- R7: When both latches of a counter are full, reads return the status byte, then the count low byte, then the count high byte.
- R8: A latch request for a latch that is already full is ignored for that latch only. The other latch of the same counter and the other selected counters are still latched.
- R9: A status latch frees after one read. A count latch frees after its high byte is read. After that, reads return live values again.
- R10: After reset all latches are empty, every byte pointer points to the low byte and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, 0 when not driven |
| dout_oe | output | 1 | Read data output enable |
| wr_cnt | output | 3 | One-hot counter write strobe |
| wr_ctl | output | 1 | Control-word write strobe (not read-back) |
| wr_data | output | 8 | Write data passed to the counters |
| live_cnt | input | 48 | Live counts, counter i at bits 16i+15:16i |
| live_stat | input | 24 | Live status bytes, counter i at bits 8i+7:8i |

## Verification
The bench targets the following cases:
- A read-back that finds the status latch already full. A design that re-latched it would return the newer status byte, and a design that dropped the whole command would leave the count unlatched.
- A mixed command across counters, where one counter has a full latch and another has empty ones. A design with one shared latch flag would lose one of them.
- Drain order with both latches full. Returning the count before the status would show up as swapped bytes.
- The release point of a count latch. Freeing it after the low byte would expose a live high byte.
- Idle bus encodings: both strobes low, a read of the control address, and chip select high. A leaky decoder would drive the bus or fire a strobe in these cases.

// File: rtl/rb_latch_ctrl.sv
module rb_latch_ctrl #(
  parameter int CW = 16,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [1:0]      addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            dout_oe,
  output logic [2:0]      wr_cnt,
  output logic            wr_ctl,
  output logic [7:0]      wr_data,
  input  logic [3*CW-1:0] live_cnt,
  input  logic [3*SW-1:0] live_stat
);
  localparam int NC = 3;

  wire wr_act = !cs_n && !wr_n && rd_n;
  wire rd_act = !cs_n && !rd_n && wr_n;
  wire ctl_sel = (addr == 2'd3);
  wire rb_cmd = wr_act && ctl_sel && (din[7:6] == 2'b11);

  assign wr_cnt  = (wr_act && !ctl_sel) ? (3'b001 << addr) : 3'b000;
  assign wr_ctl  = wr_act && ctl_sel && (din[7:6] != 2'b11);
  assign wr_data = din;
  assign dout_oe = rd_act && !ctl_sel;

  logic          cl_full [NC];
  logic          sl_full [NC];
  logic          byte_hi [NC];
  logic [CW-1:0] cl_val  [NC];
  logic [SW-1:0] sl_val  [NC];
  logic [7:0]    rd_byte;

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NC; i++) begin
      if (addr == i[1:0]) begin
        if (sl_full[i])
          rd_byte = sl_val[i][7:0];
        else if (cl_full[i])
          rd_byte = byte_hi[i] ? cl_val[i][15:8] : cl_val[i][7:0];
        else
          rd_byte = byte_hi[i] ? live_cnt[i*CW+8 +: 8] : live_cnt[i*CW +: 8];
      end
    end
  end

  assign dout = dout_oe ? rd_byte : 8'h00;

  for (genvar g = 0; g < NC; g++) begin : g_ch
    wire rd_me = rd_act && (addr == g);
    wire rb_me = rb_cmd && din[g+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cl_full[g] <= 1'b0;
        sl_full[g] <= 1'b0;
        byte_hi[g] <= 1'b0;
        cl_val[g]  <= '0;
        sl_val[g]  <= '0;
      end else begin
        if (rd_me) begin
          if (sl_full[g]) begin
            sl_full[g] <= 1'b0;
          end else begin
            byte_hi[g] <= !byte_hi[g];
            if (cl_full[g] && byte_hi[g]) cl_full[g] <= 1'b0;
          end
        end
        if (rb_me) begin
          if (!din[5] && !cl_full[g]) begin
            cl_full[g] <= 1'b1;
            cl_val[g]  <= live_cnt[g*CW +: CW];
            byte_hi[g] <= 1'b0;
          end
          if (!din[4] && !sl_full[g]) begin
            sl_full[g] <= 1'b1;
            sl_val[g]  <= live_stat[g*SW +: SW];
          end
        end
      end
    end

    p_count_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_full[g] && $past(cl_full[g])) |-> $stable(cl_val[g]));
    p_status_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sl_full[g] && $past(sl_full[g])) |-> $stable(sl_val[g]));
    p_count_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cl_full[g]) |-> $past(rd_act && addr == g && byte_hi[g]));
    p_status_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sl_full[g]) |-> $past(rd_act && addr == g));
    p_status_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sl_full[g] && rd_act && addr == g) |=> ($stable(cl_full[g]) && $stable(byte_hi[g])));
  end

  p_wr_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_cnt));
  p_bus_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || (rd_n == wr_n)) |-> (!dout_oe && wr_cnt == 3'b000 && !wr_ctl));
  p_ctl_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |-> (wr_cnt == 3'b000 && !dout_oe));
endmodule

// File: tb/rb_latch_ctrl_tb.sv
module rb_latch_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, wr_data;
  logic dout_oe, wr_ctl;
  logic [2:0] wr_cnt;
  logic [47:0] live_cnt = '0;
  logic [23:0] live_stat = '0;
  int checks = 0, failures = 0;

  bit mcf[3], msf[3], mhi[3];
  logic [15:0] mcv[3];
  logic [7:0] msv[3];

  always #4 clk = !clk;

  rb_latch_ctrl dut_i (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .din, .dout,
    .dout_oe, .wr_cnt, .wr_ctl, .wr_data, .live_cnt, .live_stat);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i);
    logic [15:0] src;
    if (msf[i]) return msv[i];
    src = mcf[i] ? mcv[i] : live_cnt[i*16 +: 16];
    return mhi[i] ? src[15:8] : src[7:0];
  endfunction

  task automatic set_live(logic [15:0] c0, logic [15:0] c1, logic [15:0] c2, logic [23:0] s);
    @(negedge clk);
    live_cnt = {c2, c1, c0};
    live_stat = s;
  endtask

  task automatic idle_chk(logic c, logic r, logic w, logic [1:0] a);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; din = 8'hC2;
    #3;
    chk(!dout_oe && dout == 0 && wr_cnt == 0 && !wr_ctl, "R3",
        {dout_oe, wr_cnt, wr_ctl, dout}, 0);
    @(negedge clk);
    cs_n = 1; rd_n = 1; wr_n = 1;
  endtask

  task automatic rd(int i, string req);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 0; rd_n = 0; wr_n = 1; addr = 2'(i);
    #3;
    e = exp_byte(i);
    chk(dout_oe && dout == e, req, dout, e);
    if (msf[i]) msf[i] = 0;
    else begin
      if (mcf[i] && mhi[i]) mcf[i] = 0;
      mhi[i] = !mhi[i];
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string req);
    logic [2:0] ec;
    logic ectl;
    @(negedge clk);
    cs_n = 0; wr_n = 0; rd_n = 1; addr = a; din = d;
    #3;
    ec = (a == 3) ? 3'b000 : 3'b001 << a;
    ectl = (a == 3) && d[7:6] != 2'b11;
    chk(wr_cnt == ec && wr_ctl == ectl && wr_data == d && !dout_oe, req,
        {wr_cnt, wr_ctl}, {ec, ectl});
    if (a == 3 && d[7:6] == 2'b11)
      for (int i = 0; i < 3; i++)
        if (d[i+1]) begin
          if (!d[5] && !mcf[i]) begin mcf[i] = 1; mcv[i] = live_cnt[i*16 +: 16]; mhi[i] = 0; end
          if (!d[4] && !msf[i]) begin msf[i] = 1; msv[i] = live_stat[i*8 +: 8]; end
        end
    @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin mcf[i] = 0; msf[i] = 0; mhi[i] = 0; mcv[i] = 0; msv[i] = 0; end
    live_cnt = {16'h2222, 16'h1111, 16'hA55A};
    live_stat = 24'h332211;
    #20;
    chk(!dout_oe && dout == 0, "R10", dout_oe, 0);
    @(negedge clk); rst_n = 1;
    rd(0, "R10");
    rd(0, "R4");
    rd(1, "R4");
    for (int a = 0; a < 3; a++) wr(2'(a), 8'(8'h40 + a), "R1");
    wr(3, 8'h36, "R2");
    wr(3, 8'hFE, "R2");
    idle_chk(1, 0, 1, 0);
    idle_chk(0, 1, 1, 1);
    idle_chk(0, 0, 0, 2);
    idle_chk(0, 0, 1, 3);
    rd(1, "R4");
    wr(3, 8'hD4, "R5");
    set_live(16'h0BAD, 16'hBEEF, 16'h2222, 24'h332211);
    rd(1, "R5"); rd(1, "R5");
    rd(1, "R9");
    rd(1, "R9");
    wr(3, 8'hE2, "R6");
    set_live(16'h0BAD, 16'hBEEF, 16'h2222, 24'h3322FF);
    rd(0, "R6"); rd(0, "R9");
    rd(0, "R4");
    wr(3, 8'hC8, "R7");
    set_live(16'h0BAD, 16'hBEEF, 16'h7777, 24'h0022FF);
    rd(2, "R7"); rd(2, "R7"); rd(2, "R7"); rd(2, "R9");
    rd(2, "R9");
    wr(3, 8'hE4, "R8");
    set_live(16'h1357, 16'h2468, 16'h7777, 24'h00AA77);
    wr(3, 8'hC6, "R8");
    set_live(16'hFFFF, 16'hEEEE, 16'h7777, 24'h000000);
    rd(1, "R8"); rd(1, "R8"); rd(1, "R8");
    rd(0, "R8"); rd(0, "R8"); rd(0, "R8");
    rd(1, "R9"); rd(0, "R9");
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 2) set_live(16'($urandom), 16'($urandom), 16'($urandom), 24'($urandom));
      else if (op < 4) wr(3, {2'b11, 6'($urandom)}, "R8");
      else if (op < 8) rd($urandom_range(0, 2), "R7");
      else if (op < 9) wr(2'($urandom), 8'($urandom), "R2");
      else idle_chk(1'($urandom), 1'b1, 1'b1, 2'($urandom));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule